// File: doc/BRIEF.md
# Correlation Result Serializer and Divider

This block is the final stage of a row-parallel image correlation engine. A bank of upstream accumulators delivers, once per window period, one numerator sum and one denominator sum for each of `LANES` neighbouring pixels, all in the same cycle. The block latches the whole set on a load strobe and walks through it one entry per cycle, numerator first, then denominator, lane by lane. It turns each pair into the squared correlation coefficient `num^2 / (den * kvar)`. `kvar` is the kernel's constant variance term, held steady by the caller.

A single squarer and a single variance multiplier feed one pipelined restoring divider. This one divider is shared by every lane. It takes a new pair every second cycle, so a full set of `LANES` results leaves the block within `2*LANES` cycles of the first one. The quotient is an unsigned fixed-point value with `FRAC_W` fraction bits. If a divisor is zero, the result is forced to zero and an error bit is flagged with that result.

Top module: `corr_final_result`

## Requirements
- R1: After synchronous reset, and until the first load, `res_valid` and `res_err` stay 0.
- R2: A load accepted while idle captures all lanes. Lane i's numerator is the two's complement field `num_bus[i*NUM_W +: NUM_W]`, and its unsigned denominator is `den_bus[i*DEN_W +: DEN_W]`.
- R3: A load strobe seen while a set is still being serialized is ignored. The set in flight completes unchanged, and no extra results appear.
- R4: Each result equals `floor(num^2 * 2^FRAC_W / (den * kvar))` as an unsigned value `2*NUM_W+FRAC_W` bits wide.
- R5: The numerator's sign has no effect: +v and -v with the same denominator give the same result.
- R6: When `den * kvar` is zero, `res_q` is 0 and `res_err` is 1 for that result. Otherwise `res_err` is 0.
- R7: Results leave in lane order, lane 0 first.
- R8: Lane j's result is valid exactly `2*NUM_W+FRAC_W+3+2*j` cycles after the load cycle. Two valid results are never adjacent.
- R9: Each accepted load yields exactly `LANES` single-cycle `res_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Parallel load strobe for one set of lanes |
| num_bus | input | LANES*NUM_W | Packed signed numerators, lane 0 in the low bits |
| den_bus | input | LANES*DEN_W | Packed unsigned denominators, lane 0 in the low bits |
| kvar | input | KV_W | Constant kernel variance term |
| res_valid | output | 1 | Result strobe |
| res_q | output | 2*NUM_W+FRAC_W | Fixed-point squared correlation |
| res_err | output | 1 | Divisor was zero for this result |

## Verification
The bench builds the block with four lanes, 8-bit numerators, 6-bit denominator and variance, and 6 fraction bits. This gives a 22-stage divider with a 25-cycle latency. These small widths let a 64-bit bench function compute every quotient exactly, including the full-scale case where a numerator of -128 is divided by 1. They also make a zero denominator or zero variance cheap to hit both by random draw and by directed sets. A load pulse injected mid-set exercises the busy window, which lasts only eight cycles.

// File: rtl/corr_pkg.sv
package corr_pkg;
  typedef enum logic {
    ENT_NUM = 1'b0,
    ENT_DEN = 1'b1
  } ent_kind_e;
endpackage

// File: rtl/corr_lane_serializer.sv
module corr_lane_serializer
  import corr_pkg::*;
#(
  parameter int LANES = 4,
  parameter int NUM_W = 8,
  parameter int DEN_W = 8,
  localparam int ENT_W = (NUM_W > DEN_W) ? NUM_W : DEN_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [LANES*NUM_W-1:0] num_bus,
  input  logic [LANES*DEN_W-1:0] den_bus,
  output logic                   head_valid,
  output ent_kind_e              head_kind,
  output logic [ENT_W-1:0]       head_data
);
  localparam int ENTRIES = 2 * LANES;
  localparam int CNT_W   = $clog2(ENTRIES + 1);

  logic [ENT_W-1:0] sreg [ENTRIES];
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (load && left == '0) begin
      left <= CNT_W'(ENTRIES);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load && left == '0) begin
      for (int i = 0; i < LANES; i++) begin
        sreg[2*i]   <= ENT_W'(num_bus[i*NUM_W +: NUM_W]);
        sreg[2*i+1] <= ENT_W'(den_bus[i*DEN_W +: DEN_W]);
      end
    end else if (left != '0) begin
      for (int i = 0; i < ENTRIES - 1; i++) sreg[i] <= sreg[i+1];
    end
  end

  assign head_valid = (left != '0);
  assign head_kind  = left[0] ? ENT_DEN : ENT_NUM;
  assign head_data  = sreg[0];

  p_busy_load_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (load && left != '0) |=> (left == $past(left) - 1'b1));
endmodule

// File: rtl/corr_pair_mult.sv
module corr_pair_mult
  import corr_pkg::*;
#(
  parameter int NUM_W = 8,
  parameter int DEN_W = 8,
  parameter int KV_W  = 8,
  localparam int ENT_W = (NUM_W > DEN_W) ? NUM_W : DEN_W,
  localparam int SQ_W  = 2 * NUM_W,
  localparam int DVS_W = DEN_W + KV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             head_valid,
  input  ent_kind_e        head_kind,
  input  logic [ENT_W-1:0] head_data,
  input  logic [KV_W-1:0]  kvar,
  output logic             pair_valid,
  output logic [SQ_W-1:0]  sq_q,
  output logic [DVS_W-1:0] prod_q
);
  logic [NUM_W-1:0]       num_hold;
  logic signed [SQ_W-1:0] sq_full;
  logic [DVS_W-1:0]       prod_full;

  assign sq_full   = $signed(num_hold) * $signed(num_hold);
  assign prod_full = DVS_W'(head_data[DEN_W-1:0]) * DVS_W'(kvar);

  always_ff @(posedge clk) begin
    if (head_valid && head_kind == ENT_NUM) num_hold <= head_data[NUM_W-1:0];
    if (head_valid && head_kind == ENT_DEN) begin
      sq_q   <= sq_full;
      prod_q <= prod_full;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pair_valid <= 1'b0;
    else     pair_valid <= head_valid && head_kind == ENT_DEN;
  end

  p_pair_after_den_r7: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> $past(head_valid && head_kind == ENT_DEN));
endmodule

// File: rtl/corr_div_pipe.sv
module corr_div_pipe #(
  parameter int DVD_W = 24,
  parameter int DVS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             out_valid,
  output logic [DVD_W-1:0] out_q,
  output logic             out_err
);
  for (genvar s = 0; s < DVD_W; s++) begin : g_stage
    logic [DVS_W-1:0] rem_i;
    logic [DVS_W-1:0] dvs_i;
    logic [DVD_W-1:0] qd_i;
    logic             vld_i;
    logic             err_i;
    logic [DVS_W:0]   trial;
    logic [DVS_W:0]   diff;
    logic             ge;
    logic [DVD_W-1:0] qd_q;
    logic             vld_q;
    logic             err_q;

    if (s == 0) begin : g_head
      assign rem_i = '0;
      assign dvs_i = divisor;
      assign qd_i  = dividend;
      assign vld_i = in_valid;
      assign err_i = (divisor == '0);
    end else begin : g_link
      assign rem_i = g_stage[s-1].g_keep.rem_q;
      assign dvs_i = g_stage[s-1].g_keep.dvs_q;
      assign qd_i  = g_stage[s-1].qd_q;
      assign vld_i = g_stage[s-1].vld_q;
      assign err_i = g_stage[s-1].err_q;
    end

    assign trial = {rem_i, qd_i[DVD_W-1]};
    assign diff  = trial - {1'b0, dvs_i};
    assign ge    = (trial >= {1'b0, dvs_i});

    always_ff @(posedge clk) begin
      qd_q  <= {qd_i[DVD_W-2:0], ge};
      err_q <= err_i;
      if (rst) vld_q <= 1'b0;
      else     vld_q <= vld_i;
    end

    if (s < DVD_W - 1) begin : g_keep
      logic [DVS_W-1:0] rem_q;
      logic [DVS_W-1:0] dvs_q;
      always_ff @(posedge clk) begin
        rem_q <= ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        dvs_q <= dvs_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_q     <= '0;
    end else begin
      out_valid <= g_stage[DVD_W-1].vld_q;
      out_err   <= g_stage[DVD_W-1].vld_q & g_stage[DVD_W-1].err_q;
      out_q     <= g_stage[DVD_W-1].err_q ? '0 : g_stage[DVD_W-1].qd_q;
    end
  end

  p_zero_divisor_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && divisor == '0) |=> (g_stage[0].vld_q && g_stage[0].err_q));
endmodule

// File: rtl/corr_final_result.sv
module corr_final_result
  import corr_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int NUM_W  = 8,
  parameter int DEN_W  = 8,
  parameter int KV_W   = 8,
  parameter int FRAC_W = 8,
  localparam int ENT_W = (NUM_W > DEN_W) ? NUM_W : DEN_W,
  localparam int SQ_W  = 2 * NUM_W,
  localparam int DVS_W = DEN_W + KV_W,
  localparam int DVD_W = SQ_W + FRAC_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [LANES*NUM_W-1:0] num_bus,
  input  logic [LANES*DEN_W-1:0] den_bus,
  input  logic [KV_W-1:0]        kvar,
  output logic                   res_valid,
  output logic [DVD_W-1:0]       res_q,
  output logic                   res_err
);
  logic             head_valid;
  ent_kind_e        head_kind;
  logic [ENT_W-1:0] head_data;
  logic             pair_valid;
  logic [SQ_W-1:0]  sq_q;
  logic [DVS_W-1:0] prod_q;

  corr_lane_serializer #(.LANES(LANES), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_ser (
    .clk(clk), .rst(rst), .load(load), .num_bus(num_bus), .den_bus(den_bus),
    .head_valid(head_valid), .head_kind(head_kind), .head_data(head_data)
  );

  corr_pair_mult #(.NUM_W(NUM_W), .DEN_W(DEN_W), .KV_W(KV_W)) u_mul (
    .clk(clk), .rst(rst), .head_valid(head_valid), .head_kind(head_kind),
    .head_data(head_data), .kvar(kvar), .pair_valid(pair_valid),
    .sq_q(sq_q), .prod_q(prod_q)
  );

  corr_div_pipe #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
    .clk(clk), .rst(rst), .in_valid(pair_valid),
    .dividend({sq_q, {FRAC_W{1'b0}}}), .divisor(prod_q),
    .out_valid(res_valid), .out_q(res_q), .out_err(res_err)
  );

  p_result_spacing_r8: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
endmodule

// File: tb/corr_final_result_bench.sv
`timescale 1ns/1ps
module corr_final_result_bench;
  localparam int LANES = 4, NUM_W = 8, DEN_W = 6, KV_W = 6, FRAC_W = 6;
  localparam int DVD_W = 2*NUM_W + FRAC_W;
  localparam int LAT = DVD_W + 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, load;
  logic [LANES*NUM_W-1:0] num_bus;
  logic [LANES*DEN_W-1:0] den_bus;
  logic [KV_W-1:0] kvar;
  logic res_valid, res_err;
  logic [DVD_W-1:0] res_q;

  corr_final_result #(.LANES(LANES), .NUM_W(NUM_W), .DEN_W(DEN_W), .KV_W(KV_W),
    .FRAC_W(FRAC_W)) u_corr_final_result (
    .clk(clk), .rst(rst), .load(load), .num_bus(num_bus), .den_bus(den_bus),
    .kvar(kvar), .res_valid(res_valid), .res_q(res_q), .res_err(res_err));

  int cyc = 0;
  int nchk = 0, nerr = 0, ng = 0;
  bit done = 0;
  longint got_q [64];
  bit     got_e [64];
  int     got_c [64];
  int exp_num [LANES];
  int exp_den [LANES];
  int kv_cur;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && res_valid && ng < 64) begin
      got_q[ng] = res_q;
      got_e[ng] = res_err;
      got_c[ng] = cyc;
      ng++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      nerr++;
      $display("FAIL R8 watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  function automatic longint ref_q(int n, int d, int k);
    longint dv = longint'(d) * longint'(k);
    if (dv == 0) return 0;
    return (longint'(n * n) << FRAC_W) / dv;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic run_batch(bit disturb);
    int lc;
    @(negedge clk);
    ng = 0;
    for (int i = 0; i < LANES; i++) begin
      num_bus[i*NUM_W +: NUM_W] = exp_num[i][NUM_W-1:0];
      den_bus[i*DEN_W +: DEN_W] = exp_den[i][DEN_W-1:0];
    end
    kvar = kv_cur[KV_W-1:0];
    load = 1'b1;
    lc = cyc + 1;
    @(negedge clk);
    load = 1'b0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      num_bus = ~num_bus;
      den_bus = ~den_bus;
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
    end
    while (cyc < lc + LAT + 2*LANES + 6) @(negedge clk);
    check(ng == LANES, disturb ? "R3" : "R9", "result count", ng, LANES);
    for (int j = 0; j < LANES && j < ng; j++) begin
      longint e = ref_q(exp_num[j], exp_den[j], kv_cur);
      bit ze = (exp_den[j] * kv_cur) == 0;
      check(got_q[j] == e, disturb ? "R3 R4 R7" : "R2 R4 R7", "quotient", got_q[j], e);
      check(got_e[j] == ze, "R6", "error flag", got_e[j], ze);
      check(got_c[j] == lc + LAT + 2*j, "R8", "result cycle", got_c[j], lc + LAT + 2*j);
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    rst = 1'b1; load = 1'b0; num_bus = '0; den_bus = '0; kvar = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(res_valid == 1'b0 && res_err == 1'b0, "R1", "idle outputs",
            {res_valid, res_err}, 0);
    end
    check(ng == 0, "R1", "no results before load", ng, 0);

    exp_num = '{5, -5, -128, 127}; exp_den = '{3, 3, 1, 1}; kv_cur = 1;
    run_batch(0);
    check(got_q[0] == got_q[1], "R5", "sign independence", got_q[1], got_q[0]);

    exp_num = '{10, -20, 30, -40}; exp_den = '{0, 5, 0, 63}; kv_cur = 9;
    run_batch(0);
    exp_num = '{1, 2, 3, 4}; exp_den = '{7, 7, 7, 7}; kv_cur = 0;
    run_batch(0);
    exp_num = '{-1, 100, -77, 64}; exp_den = '{63, 2, 40, 11}; kv_cur = 63;
    run_batch(1);

    for (int b = 0; b < 20; b++) begin
      for (int i = 0; i < LANES; i++) begin
        exp_num[i] = int'($urandom_range(0, 255)) - 128;
        exp_den[i] = ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(1, 63));
      end
      kv_cur = int'($urandom_range(1, 63));
      run_batch(b % 5 == 4);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule